// File: doc/BRIEF.md
# Contact Image Sensor Scan Timing Generator

This block drives a chain of cascaded linear image sensor dies from the host side. Each pixel period is divided from the system clock. In each period the block produces the sensor shift clock `cp` with a programmable high time, and a video-line reset-switch control `vrst` that is closed while `cp` is high. It also produces a one-cycle ADC sample strobe `smp_stb`. The strobe is placed where the video line has charged longest: the clock low time plus an amplifier delay, both counted from the rising clock edge.

A line starts with one start period in which the start pulse `sp` is raised. Pixel periods follow, one for each pixel of every cascaded die. Each pixel period carries the index of the pixel being sampled. After the last pixel a one-cycle `line_done` pulse is produced. Then a programmable number of idle clock periods pass before the next start pulse. The interval between start pulses is the sensor integration time. All configuration inputs are captured only at a line boundary. The block has no data stream, so every pin is a plain level or pulse with no valid/ready handshake.

Top module: `cis_scan_timer`

## Requirements
- R1: Once running, `cp` rises every `cfg_period` system clocks and stays high for `cfg_high` clocks at the start of each period.
- R2: `sp` rises one clock after a `cp` rising edge and falls one clock after the next `cp` rising edge. It is never changed in the clock where `cp` rises, and each high pulse of `sp` contains exactly one `cp` falling edge.
- R3: `vrst` equals `cp` in every clock.
- R4: In each pixel period `smp_stb` is high for exactly one clock. That clock lies `(cfg_period - cfg_high + cfg_amp)` clocks after the period's `cp` rising edge, limited to `cfg_period - 1`. The strobe never appears in the start period or in idle periods.
- R5: The pixel periods follow the start period. `pix_idx`, read with `smp_stb`, counts 0, 1, … up to `PIX_PER_DIE * N - 1`, where N is `cfg_dies` and a value of 0 is taken as 1.
- R6: `line_done` is a one-clock pulse in the final clock of the last pixel period, `cfg_period - 1 - strobe offset` clocks after the last strobe.
- R7: After `line_done`, `cfg_idle` full `cp` periods pass with no strobe and no `sp`. Consecutive `sp` rising edges are `(1 + PIX_PER_DIE*N + cfg_idle) * cfg_period` clocks apart.
- R8: Configuration inputs are captured only at a line boundary (first clock after reset, and the clock that ends a line's last period). A change during a line has no effect until the next start period.
- R9: While `rst_n` is low, and in the first clock after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PER_W | Pixel period in system clocks |
| cfg_high | input | PER_W | Clock high time in system clocks |
| cfg_dies | input | DIE_W | Number of cascaded dies (0 treated as 1) |
| cfg_amp | input | PER_W | Amplifier delay added to the strobe offset |
| cfg_idle | input | IDLE_W | Idle clock periods between lines |
| cp | output | 1 | Sensor shift clock |
| sp | output | 1 | Sensor start pulse |
| vrst | output | 1 | Video-line reset-switch control, closed when high |
| smp_stb | output | 1 | One-clock ADC sample strobe |
| pix_idx | output | PIX_W | Index of the pixel sampled by `smp_stb` |
| line_done | output | 1 | One-clock pulse after the last pixel of a line |

## Verification
The assertions take the configuration to be in range. `cfg_high` is at least 2 and at most half of `cfg_period`, so the clock's duty cycle never exceeds 50%. Because of that, the single falling edge inside `sp` and a strobe that never meets a closed reset switch follow from the timing. Within that range the strobe offset may exceed the period; the limit in R4 covers that case. The stimulus sweeps six configurations that keep to these bounds and include a zero die count and two saturated strobe offsets. Every configuration change is applied mid-line, so the capture rule of R8 is exercised each time.

// File: rtl/scan_cfg_pkg.sv
package scan_cfg_pkg;
  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_START = 2'd1,
    ST_PIX   = 2'd2,
    ST_IDLE  = 2'd3
  } line_st_t;
endpackage

// File: rtl/scan_phase.sv
module scan_phase #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] per,
  input  logic [PER_W-1:0] high,
  input  logic [PER_W-1:0] amp,
  output logic             per_end,
  output logic             cp_hit,
  output logic             stb_hit
);
  logic [PER_W-1:0] ph;
  logic [PER_W:0]   raw_pos;
  logic [PER_W:0]   last_ph;
  logic [PER_W-1:0] spos;

  always_comb begin
    last_ph = {1'b0, per} - (PER_W+1)'(1);
    raw_pos = {1'b0, per} - {1'b0, high} + {1'b0, amp};
    spos    = (raw_pos > last_ph) ? last_ph[PER_W-1:0] : raw_pos[PER_W-1:0];
  end

  assign per_end = run && ({1'b0, ph} == last_ph);
  assign cp_hit  = run && (ph < high);
  assign stb_hit = run && (ph == spos);

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= '0;
    else if (!run)    ph <= '0;
    else if (per_end) ph <= '0;
    else              ph <= ph + 1'b1;
  end

  // R1: the phase never leaves the programmed period
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph < per));
endmodule

// File: rtl/scan_line_seq.sv
module scan_line_seq
  import scan_cfg_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int DIE_W       = 5,
  parameter int IDLE_W      = 16,
  parameter int PIX_PER_DIE = 192,
  parameter int PIX_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [PER_W-1:0]  cfg_high,
  input  logic [DIE_W-1:0]  cfg_dies,
  input  logic [PER_W-1:0]  cfg_amp,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              per_end,
  input  logic              stb_hit,
  output logic              run,
  output logic [PER_W-1:0]  act_per,
  output logic [PER_W-1:0]  act_high,
  output logic [PER_W-1:0]  act_amp,
  output logic              sp_d,
  output logic              stb_d,
  output logic [PIX_W-1:0]  idx_d,
  output logic              done_d
);
  line_st_t          st;
  logic [DIE_W-1:0]  act_dies;
  logic [IDLE_W-1:0] act_idle;
  logic [PIX_W-1:0]  pcnt;
  logic [IDLE_W-1:0] icnt;
  logic              p_first;
  logic [DIE_W-1:0]  n_eff;
  logic [PIX_W-1:0]  tot;
  logic              last_pix;
  logic              load;

  assign n_eff    = (act_dies == '0) ? DIE_W'(1) : act_dies;
  assign tot      = PIX_W'(PIX_PER_DIE) * PIX_W'(n_eff);
  assign last_pix = (pcnt == tot - 1'b1);
  assign load     = (st == ST_BOOT) ||
                    (per_end && st == ST_PIX && last_pix && act_idle == '0) ||
                    (per_end && st == ST_IDLE && icnt == act_idle - 1'b1);
  assign run      = (st != ST_BOOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_per  <= '0;
      act_high <= '0;
      act_amp  <= '0;
      act_dies <= '0;
      act_idle <= '0;
    end else if (load) begin
      act_per  <= cfg_period;
      act_high <= cfg_high;
      act_amp  <= cfg_amp;
      act_dies <= cfg_dies;
      act_idle <= cfg_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_BOOT;
      pcnt    <= '0;
      icnt    <= '0;
      p_first <= 1'b0;
    end else begin
      p_first <= load || per_end;
      case (st)
        ST_BOOT: st <= ST_START;
        ST_START: if (per_end) begin
          st   <= ST_PIX;
          pcnt <= '0;
        end
        ST_PIX: if (per_end) begin
          if (last_pix) begin
            icnt <= '0;
            st   <= (act_idle == '0) ? ST_START : ST_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: if (per_end) begin
          if (icnt == act_idle - 1'b1) st <= ST_START;
          else                         icnt <= icnt + 1'b1;
        end
      endcase
    end
  end

  assign sp_d   = (st == ST_START && !p_first) || (st == ST_PIX && pcnt == '0 && p_first);
  assign stb_d  = (st == ST_PIX) && stb_hit;
  assign idx_d  = pcnt;
  assign done_d = (st == ST_PIX) && per_end && last_pix;

  // R5: a strobe always names a pixel inside the line
  a_r5_idx_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    stb_d |-> (pcnt < tot));
  // R7: the idle period counter stays below the programmed count
  a_r7_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (icnt < act_idle));
  // R8: captured settings move only at a boundary
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_per) && $stable(act_high) && $stable(act_dies) && $stable(act_idle)));
endmodule

// File: rtl/cis_scan_timer.sv
module cis_scan_timer #(
  parameter int PER_W       = 8,
  parameter int DIE_W       = 5,
  parameter int IDLE_W      = 16,
  parameter int PIX_PER_DIE = 192,
  localparam int MAX_PIX    = PIX_PER_DIE * ((1 << DIE_W) - 1),
  localparam int PIX_W      = $clog2(MAX_PIX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [PER_W-1:0]  cfg_high,
  input  logic [DIE_W-1:0]  cfg_dies,
  input  logic [PER_W-1:0]  cfg_amp,
  input  logic [IDLE_W-1:0] cfg_idle,
  output logic              cp,
  output logic              sp,
  output logic              vrst,
  output logic              smp_stb,
  output logic [PIX_W-1:0]  pix_idx,
  output logic              line_done
);
  logic             run, per_end, cp_hit, stb_hit;
  logic [PER_W-1:0] act_per, act_high, act_amp;
  logic             sp_d, stb_d, done_d;
  logic [PIX_W-1:0] idx_d;

  scan_line_seq #(
    .PER_W(PER_W), .DIE_W(DIE_W), .IDLE_W(IDLE_W),
    .PIX_PER_DIE(PIX_PER_DIE), .PIX_W(PIX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_high(cfg_high), .cfg_dies(cfg_dies),
    .cfg_amp(cfg_amp), .cfg_idle(cfg_idle),
    .per_end(per_end), .stb_hit(stb_hit),
    .run(run), .act_per(act_per), .act_high(act_high), .act_amp(act_amp),
    .sp_d(sp_d), .stb_d(stb_d), .idx_d(idx_d), .done_d(done_d)
  );

  scan_phase #(.PER_W(PER_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run),
    .per(act_per), .high(act_high), .amp(act_amp),
    .per_end(per_end), .cp_hit(cp_hit), .stb_hit(stb_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp        <= 1'b0;
      vrst      <= 1'b0;
      sp        <= 1'b0;
      smp_stb   <= 1'b0;
      pix_idx   <= '0;
      line_done <= 1'b0;
    end else begin
      cp        <= cp_hit;
      vrst      <= cp_hit;
      sp        <= sp_d;
      smp_stb   <= stb_d;
      pix_idx   <= idx_d;
      line_done <= done_d;
    end
  end

  // checker state: falling edges of cp seen inside the current sp pulse
  logic       cp_dly;
  logic [1:0] fall_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_dly   <= 1'b0;
      fall_cnt <= '0;
    end else begin
      cp_dly <= cp;
      if (!sp)                             fall_cnt <= '0;
      else if (cp_dly && !cp && fall_cnt != 2'd3) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R2: sp holds still across a rising cp edge
  a_r2_sp_still_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp) |-> $stable(sp));
  // R2: no second falling edge within one sp pulse
  a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sp && cp_dly && !cp) |-> (fall_cnt == 2'd0));
  // R4: the strobe never meets a closed reset switch
  a_r4_stb_switch_open: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> !vrst);
  // R6: line_done lasts one clock
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
endmodule

// File: tb/sim_cis_scan_timer.sv
`timescale 1ns/1ps
module sim_cis_scan_timer;
  localparam int PER_W = 4, DIE_W = 2, IDLE_W = 3, PPD = 3;
  localparam int NCFG = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PER_W-1:0] cfg_period, cfg_high, cfg_amp;
  logic [DIE_W-1:0] cfg_dies;
  logic [IDLE_W-1:0] cfg_idle;
  logic cp, sp, vrst, smp_stb, line_done;
  logic [3:0] pix_idx;

  always #2.5 clk = ~clk;

  cis_scan_timer #(.PER_W(PER_W), .DIE_W(DIE_W), .IDLE_W(IDLE_W), .PIX_PER_DIE(PPD)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_high(cfg_high),
    .cfg_dies(cfg_dies), .cfg_amp(cfg_amp), .cfg_idle(cfg_idle),
    .cp(cp), .sp(sp), .vrst(vrst), .smp_stb(smp_stb), .pix_idx(pix_idx),
    .line_done(line_done));

  int t_per[NCFG]  = '{4, 4, 8, 8, 6, 5};
  int t_high[NCFG] = '{2, 2, 2, 4, 3, 2};
  int t_amp[NCFG]  = '{0, 1, 3, 5, 0, 1};
  int t_dies[NCFG] = '{1, 2, 1, 1, 0, 3};
  int t_idle[NCFG] = '{0, 1, 2, 0, 1, 0};

  int checks = 0, errors = 0;
  int pend_per, pend_high, pend_amp, pend_dies, pend_idle;
  int cur_per, cur_high, cur_amp, cur_idle, cur_tot, cur_spos;
  int done_cnt = 0, stb_total = 0;
  bit chg_pending = 0, finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(int k);
    pend_per = t_per[k]; pend_high = t_high[k]; pend_amp = t_amp[k];
    pend_dies = t_dies[k]; pend_idle = t_idle[k];
    cfg_period = PER_W'(pend_per); cfg_high = PER_W'(pend_high);
    cfg_amp = PER_W'(pend_amp); cfg_dies = DIE_W'(pend_dies);
    cfg_idle = IDLE_W'(pend_idle);
  endtask

  // monitor, sampled away from the active edge
  int cyc = 0, rise_c = 0, prev_rise = -1, sp_rise = -1;
  int stb_in_per = 0, stb_in_line = 0, idx_exp = 0, falls_sp = 0;
  int last_stb_c = 0, stb_after_done = 0;
  bit pcp = 0, psp = 0, pdone = 0, after_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(vrst == cp, "R3 vrst follows cp", int'(vrst), int'(cp));
      if (cp && !pcp) begin
        if (prev_rise >= 0) chk(cyc - prev_rise == cur_per, "R1 cp period", cyc - prev_rise, cur_per);
        chk(stb_in_per <= 1, "R4 one strobe per period", stb_in_per, 1);
        chk(sp == psp, "R2 sp steady at cp rise", int'(sp), int'(psp));
        stb_in_per = 0; prev_rise = cyc; rise_c = cyc;
      end
      if (sp && !psp) begin
        chk(cyc == rise_c + 1, "R2 sp rise position", cyc - rise_c, 1);
        if (sp_rise >= 0) begin
          chk(cyc - sp_rise == (1 + cur_tot + cur_idle) * cur_per, "R7 integration interval",
              cyc - sp_rise, (1 + cur_tot + cur_idle) * cur_per);
          chk(stb_after_done == 0, "R7 no strobe while idle", stb_after_done, 0);
        end
        cur_per = pend_per; cur_high = pend_high; cur_amp = pend_amp; cur_idle = pend_idle;
        cur_tot = PPD * ((pend_dies == 0) ? 1 : pend_dies);
        cur_spos = cur_per - cur_high + cur_amp;
        if (cur_spos > cur_per - 1) cur_spos = cur_per - 1;
        sp_rise = cyc; stb_in_line = 0; idx_exp = 0; falls_sp = 0;
        after_done = 0; stb_after_done = 0;
      end
      if (!sp && psp) begin
        chk(cyc == rise_c + 1, "R2 sp fall position", cyc - rise_c, 1);
        chk(falls_sp == 1, "R2 one cp fall inside sp", falls_sp, 1);
      end
      if (!cp && pcp) begin
        chk(cyc - rise_c == cur_high, "R1 cp high time", cyc - rise_c, cur_high);
        if (sp) falls_sp++;
      end
      if (smp_stb) begin
        stb_in_per++; stb_in_line++; stb_total++;
        chk(cyc == rise_c + cur_spos, "R4 strobe offset", cyc - rise_c, cur_spos);
        chk(int'(pix_idx) == idx_exp, "R5 pixel index", int'(pix_idx), idx_exp);
        idx_exp++; last_stb_c = cyc;
        if (after_done) stb_after_done++;
      end
      if (line_done) begin
        chk(!pdone, "R6 done single clock", int'(pdone), 0);
        chk(stb_in_line == cur_tot, "R5 pixels per line", stb_in_line, cur_tot);
        chk(cyc - last_stb_c == cur_per - 1 - cur_spos, "R6 done position",
            cyc - last_stb_c, cur_per - 1 - cur_spos);
        if (chg_pending) begin
          chk(stb_in_line == cur_tot, "R8 mid-line change ignored", stb_in_line, cur_tot);
          chg_pending = 0;
        end
        after_done = 1; done_cnt++;
      end
      pcp = cp; psp = sp; pdone = line_done;
    end
  end

  initial begin
    apply(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({cp, sp, vrst, smp_stb, line_done} == 5'b0, "R9 outputs low in reset",
        int'({cp, sp, vrst, smp_stb, line_done}), 0);
    chk(pix_idx == '0, "R9 index zero in reset", int'(pix_idx), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk({cp, sp, smp_stb, line_done} == 4'b0, "R9 quiet first clock after reset",
        int'({cp, sp, smp_stb, line_done}), 0);
    for (int k = 1; k < NCFG; k++) begin
      int target, s0;
      target = done_cnt + 2;
      wait (done_cnt >= target);
      s0 = stb_total;
      wait (stb_total > s0);
      @(posedge clk); #1;
      apply(k);
      chg_pending = 1;
    end
    begin
      int target;
      target = done_cnt + 3;
      wait (done_cnt >= target);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule